// File: doc/BRIEF.md
# Falling-Edge Sampled Rollback Controller

This controller sits in front of a combinational logic block that is watched by a current sensor. The sensor raises an asynchronous error flag when a transient fault strikes, and the flag stays set until the sensor is reset. Each rising clock edge normally loads the block's working inputs from the upstream source. While no fault is pending, the controller also copies the inputs that were applied during the cycle just ended into a single one-entry history register.

The error flag is captured on the falling clock edge into a recompute signal. Sampling half a cycle early means that when recompute is high at a rising edge, the history register still holds the inputs of the cycle the fault corrupted. The controller drives those saved inputs back onto the logic block and pulses the sensor reset. If the fault outlasts the replay, the sensor sets the flag again and the same saved inputs are replayed once more. This repeats until one cycle completes without a fault.

A fault that begins late in one cycle and ends early in the next costs two extra cycles. A fault that begins in cycle 1 and lasts into cycle 3 costs three extra cycles. Upstream logic uses the recompute output to hold off new work.

Top module: `replay_recovery_ctrl`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, `appliedIn`, the history register, `recompute` and `sensorRst` are all cleared to 0.
- R2: At a rising edge where `recompute` is 0, `appliedIn` takes the value of `newIn` present at that edge, so it follows `newIn` with one cycle of latency.
- R3: `recompute` changes only at falling clock edges, where it takes the level of `errFlag`. A flag that rises after a falling edge does not show on `recompute` until the next falling edge.
- R4: At a rising edge where `recompute` is 1, `appliedIn` is loaded with the value it held during the cycle before the one in which `recompute` was first set. That cycle is the last one that ended with `recompute` at 0.
- R5: The history register is not written while `recompute` is 1. Back-to-back replays therefore present the same value on `appliedIn`.
- R6: `sensorRst` is 1 during exactly the cycles that follow a rising edge at which `recompute` was 1, and 0 after every other rising edge.
- R7: A fault that sets the flag after the falling edge of cycle k and clears before the falling edge of cycle k+2 causes one replay, for two extra cycles. A fault that persists past the sensor reset in the first replay cycle causes two replays, for three extra cycles.
- R8: In the first cycle after `recompute` returns to 0, `appliedIn` again takes `newIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge loads the inputs, falling edge samples the flag |
| rst | input | 1 | Synchronous reset, active high |
| newIn | input | WIDTH | Fresh inputs from the upstream source |
| errFlag | input | 1 | Asynchronous, self-holding fault flag from the current sensor |
| appliedIn | output | WIDTH | Inputs currently driven into the guarded logic block |
| recompute | output | 1 | High while a replay of the saved inputs is requested |
| sensorRst | output | 1 | Reset pulse to the sensor, high during each replay cycle |

## Verification
If the history register is written during a replay, the second consecutive replay puts a different value on `appliedIn`. That difference appears at the ports one cycle after the replay starts. If the flag capture uses the wrong edge, `recompute` moves half a cycle early or late. The bench samples `recompute` on both sides of the falling edge, so the error is caught within that cycle. A wrong reset pulse changes whether a persisting fault re-raises the flag, which alters the replay count checked at the end of each fault scenario.

// File: rtl/replay_recovery_pkg.sv
package replay_recovery_pkg;

  // Strobes sent from the control to the datapath every cycle.
  typedef struct packed {
    logic replaySel;   // pick the history register for the next applied value
    logic histWe;      // capture the current applied value into history
  } rrStrobe_t;

endpackage

// File: rtl/replay_recovery_ctrl_fsm.sv
module replay_recovery_ctrl_fsm
  import replay_recovery_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      errFlag,
  output logic      recompute,
  output logic      sensorRst,
  output rrStrobe_t strobe
);

  // Capture the flag half a cycle early so only one cycle of history is needed.
  always_ff @(negedge clk) begin
    if (rst) recompute <= 1'b0;
    else     recompute <= errFlag;
  end

  // The sensor reset covers the cycle in which each replay executes.
  always_ff @(posedge clk) begin
    if (rst) sensorRst <= 1'b0;
    else     sensorRst <= recompute;
  end

  always_comb begin
    strobe.replaySel = recompute;
    strobe.histWe    = ~recompute;   // freeze history while a replay is pending
  end

endmodule

// File: rtl/replay_recovery_datapath.sv
module replay_recovery_datapath
  import replay_recovery_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  rrStrobe_t        strobe,
  input  logic [WIDTH-1:0] newIn,
  output logic [WIDTH-1:0] appliedIn
);

  logic [WIDTH-1:0] histQ;
  logic [WIDTH-1:0] nextApplied;

  // 2:1 selection between fresh inputs and the saved ones.
  always_comb nextApplied = strobe.replaySel ? histQ : newIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      histQ     <= '0;
      appliedIn <= '0;
    end else begin
      if (strobe.histWe) histQ <= appliedIn;
      appliedIn <= nextApplied;
    end
  end

endmodule

// File: rtl/replay_recovery_ctrl.sv
module replay_recovery_ctrl
  import replay_recovery_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] newIn,
  input  logic             errFlag,
  output logic [WIDTH-1:0] appliedIn,
  output logic             recompute,
  output logic             sensorRst
);

  rrStrobe_t strobe;

  replay_recovery_ctrl_fsm ctrlI (
    .clk       (clk),
    .rst       (rst),
    .errFlag   (errFlag),
    .recompute (recompute),
    .sensorRst (sensorRst),
    .strobe    (strobe)
  );

  replay_recovery_datapath #(.WIDTH(WIDTH)) dpI (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .newIn     (newIn),
    .appliedIn (appliedIn)
  );

endmodule

// File: rtl/replay_recovery_ctrl_chk.sv
module replay_recovery_ctrl_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] newIn,
  input logic             errFlag,
  input logic [WIDTH-1:0] appliedIn,
  input logic             recompute,
  input logic             sensorRst
);

  AST_APPLY_FRESH: assert property (@(posedge clk) disable iff (rst)
    !recompute |=> (appliedIn == $past(newIn))); // R2

  AST_FLAG_CAPTURE_HI: assert property (@(negedge clk) disable iff (rst)
    errFlag |=> recompute); // R3

  AST_FLAG_CAPTURE_LO: assert property (@(negedge clk) disable iff (rst)
    !errFlag |=> !recompute); // R3

  AST_REPLAY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (recompute && $past(recompute)) |=> $stable(appliedIn)); // R5

  AST_SRST_ON: assert property (@(posedge clk) disable iff (rst)
    recompute |=> sensorRst); // R6

  AST_SRST_OFF: assert property (@(posedge clk) disable iff (rst)
    !recompute |=> !sensorRst); // R6

endmodule

bind replay_recovery_ctrl replay_recovery_ctrl_chk #(.WIDTH(WIDTH)) chkI (
  .clk       (clk),
  .rst       (rst),
  .newIn     (newIn),
  .errFlag   (errFlag),
  .appliedIn (appliedIn),
  .recompute (recompute),
  .sensorRst (sensorRst)
);

// File: tb/tb_replay_recovery_ctrl.sv
`timescale 1ns/1ps
module tb_replay_recovery_ctrl;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] newIn = '0;
  logic         errFlag = 1'b0;
  logic [W-1:0] appliedIn;
  logic         recompute;
  logic         sensorRst;

  always #5 clk = ~clk;   // 100 MHz

  replay_recovery_ctrl #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .newIn(newIn), .errFlag(errFlag),
    .appliedIn(appliedIn), .recompute(recompute), .sensorRst(sensorRst)
  );

  int total = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [W-1:0] appliedLog[$];
  logic [W-1:0] lastNew = '0;
  logic [W-1:0] target = '0;
  logic [W-1:0] expApplied;
  bit expRec = 0;
  bit expSr = 0;
  bit prevSr = 0;
  bit faultOn = 0;
  int replays = 0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock cycle: fHi = fault present from the rising-edge side,
  // fLo = fault present after the falling edge.
  task automatic runCycle(input logic [W-1:0] v, input bit fHi, input bit fLo);
    string tag;
    @(posedge clk);
    expApplied = expRec ? target : lastNew;
    prevSr = expSr;
    expSr = expRec;
    if (expRec) replays++;
    #1;
    if (sensorRst) errFlag = 1'b0;   // sensor model: reset clears the latch
    if (faultOn) errFlag = 1'b1;
    #1;
    newIn = v; lastNew = v;
    faultOn = fHi;
    if (fHi) errFlag = 1'b1;
    #2;
    if (expSr && prevSr)  tag = "R5";
    else if (expSr)       tag = "R4";
    else if (prevSr)      tag = "R8";
    else                  tag = "R2";
    chk(appliedIn == expApplied, tag, appliedIn, expApplied);
    chk(sensorRst == expSr, "R6", {{(W-1){1'b0}}, sensorRst}, {{(W-1){1'b0}}, expSr});
    chk(recompute == expRec, "R3 before fall", {{(W-1){1'b0}}, recompute}, {{(W-1){1'b0}}, expRec});
    appliedLog.push_back(expApplied);
    #2;
    if (errFlag && !expRec) target = appliedLog[$-1];
    expRec = errFlag;
    chk(recompute == expRec, "R3 after fall", {{(W-1){1'b0}}, recompute}, {{(W-1){1'b0}}, expRec});
    #1;
    faultOn = fLo;
    if (fLo) errFlag = 1'b1;
  endtask

  task automatic checkReplays(input int exp, input string req);
    total++;
    if (replays != exp) begin
      fails++;
      $display("FAIL %s extra cycles actual=%0d expected=%0d", req, replays + 1, exp + 1);
    end
    replays = 0;
  endtask

  initial begin
    // R1: reset state
    rst = 1'b1;
    newIn = 16'hA5A5;
    repeat (3) @(posedge clk);
    #4;
    chk(appliedIn == '0, "R1 appliedIn", appliedIn, '0);
    chk(sensorRst == 1'b0, "R1 sensorRst", {{(W-1){1'b0}}, sensorRst}, '0);
    #2;
    chk(recompute == 1'b0, "R1 recompute", {{(W-1){1'b0}}, recompute}, '0);
    newIn = '0;
    lastNew = '0;
    appliedLog.push_back('0);
    @(posedge clk);
    #2 rst = 1'b0;

    // R2: fault-free streaming with several patterns
    for (int i = 0; i < 6; i++) runCycle(W'(16'h1000 + i), 0, 0);
    runCycle(16'hFFFF, 0, 0);
    runCycle(16'h0000, 0, 0);
    runCycle(16'h5555, 0, 0);
    runCycle(16'hAAAA, 0, 0);
    replays = 0;

    // R7 short: flag rises after the fall of one cycle, gone before the next
    runCycle(16'h2001, 0, 1);
    runCycle(16'h2002, 1, 0);
    for (int i = 0; i < 4; i++) runCycle(W'(16'h2100 + i), 0, 0);
    checkReplays(1, "R7 short");

    // R7 long: fault persists into the first replay cycle (R5 back-to-back replay)
    runCycle(16'h3001, 0, 1);
    runCycle(16'h3002, 1, 1);
    runCycle(16'h3003, 1, 0);
    for (int i = 0; i < 4; i++) runCycle(W'(16'h3100 + i), 0, 0);
    checkReplays(2, "R7 long");

    // R4: fault seen before the falling edge of its own cycle
    runCycle(16'h4001, 1, 0);
    for (int i = 0; i < 4; i++) runCycle(W'(16'h4100 + i), 0, 0);
    checkReplays(1, "R4 early");

    // R5: very long fault, three consecutive replays
    runCycle(16'h5001, 0, 1);
    runCycle(16'h5002, 1, 1);
    runCycle(16'h5003, 1, 1);
    runCycle(16'h5004, 1, 0);
    for (int i = 0; i < 4; i++) runCycle(W'(16'h5100 + i), 0, 0);
    checkReplays(3, "R5 long");

    // R8: faults back to back after a clean cycle
    runCycle(16'h6001, 0, 1);
    runCycle(16'h6002, 1, 0);
    runCycle(16'h6003, 0, 1);
    runCycle(16'h6004, 1, 0);
    for (int i = 0; i < 4; i++) runCycle(W'(16'h6100 + i), 0, 0);
    checkReplays(2, "R8 repeated");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule